// File: doc/BRIEF.md
# I2C Write-Only Control Register Slave

This block is a serial-bus slave that lets an external master load a small bank of 8-bit control registers. The bus clock and data lines are brought into a faster system clock domain, where a byte engine picks out START and STOP, checks the device address, and answers each accepted byte with an acknowledge by pulling the data line low.

A write transaction carries three parts. The first is the device address with a direction bit. The second is a register sub-address that loads a 5-bit register pointer. Then come any number of data bytes. Each data byte lands in the register the pointer selects, and the pointer then steps by one. After the last register (index 19) the pointer returns to index 0. One bit of the device address comes from a strap pin, so two such slaves can share a bus.

The register contents are visible at all times through a plain parallel select and value port. There is no stream data path, so there is no valid/ready handshake and no back-pressure. The bus master cannot be stalled, because clock stretching is not used.

Top module: `i2cw_slave`

## Requirements
- R1: A falling SDA while SCL is high (START) starts an address byte. A rising SDA while SCL is high (STOP) returns the slave to idle and releases SDA. Bytes clocked after a STOP without a new START get no acknowledge and change no register.
- R2: The address byte is received MSB first. Its upper seven bits must equal binary 001000 followed by the strap pin level, and its last bit (R/W) must be 0. Such a byte is acknowledged.
- R3: An address byte that does not match, or a matching one with R/W equal to 1, gets no acknowledge. The rest of the transfer is then ignored and no register changes.
- R4: For every accepted byte, sda_pull_o is high throughout the ninth SCL high period. It drops within a few system clocks after the ninth SCL falling edge.
- R5: The second byte's low five bits load the register pointer. Each later byte, taken MSB first, is written to the register the pointer names and is acknowledged.
- R6: After each stored data byte the pointer increments by one. From 19 (13h) it wraps to 0, so later bytes overwrite the lowest registers.
- R7: A sub-address above 13h, or one with any of its top three bits set, is acknowledged, and so are the data bytes that follow it. Those data bytes change no register until a new sub-address is received.
- R8: A repeated START in the middle of a transfer drops the current transfer and expects a new address byte.
- R9: After reset every register reads 0 and sda_pull_o is low.
- R10: reg_val_o shows the register selected by reg_sel_i in the same cycle. Selects from 20 to 31 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock level as seen on the wire |
| sda_i | input | 1 | Bus data level as seen on the wire |
| strap_i | input | 1 | Strap level that sets the lowest device address bit |
| sda_pull_o | output | 1 | High to pull the bus data line low (acknowledge) |
| reg_sel_i | input | 5 | Register index for the readout port |
| reg_val_o | output | 8 | Contents of the selected register |

## Verification
The assertions assume the master follows the bus rules. SDA moves only while SCL is low, except at START and STOP. Each SCL phase lasts well beyond the synchroniser latency. The master releases SDA during the acknowledge clock and never tries a START or STOP while the slave holds SDA low. The bench models the wired-AND data line and holds each SCL half period for ten system clocks. It changes SDA only in the middle of the low phase and samples the acknowledge in the middle of the ninth high phase. Under these conditions the acknowledge-timing and pointer-wrap properties hold.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_SUB, PH_DATA} phase_t;
  typedef enum logic [1:0] {AK_NONE, AK_WAIT, AK_DRIVE} ack_t;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[STAGES-2:0], scl_i};
      sda_q <= {sda_q[STAGES-2:0], sda_i};
      scl_p <= scl_q[STAGES-1];
      sda_p <= sda_q[STAGES-1];
    end
  end

  assign scl_s     = scl_q[STAGES-1];
  assign sda_s     = sda_q[STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
#(
  parameter int          DW     = 8,
  parameter int          PW     = 5,
  parameter int          NREG   = 20,
  parameter logic [DW-3:0] DEV_HI = 6'b001000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_det,
  input  logic          stop_det,
  input  logic          strap_i,
  output logic          sda_pull_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int BW = $clog2(DW);
  localparam logic [BW-1:0] LASTBIT = BW'(DW - 1);
  localparam logic [PW-1:0] LASTP   = PW'(NREG - 1);

  phase_t          phase;
  ack_t            ack;
  logic [BW-1:0]   bitcnt;
  logic [DW-2:0]   shreg;
  logic [PW-1:0]   ptr;
  logic            ptr_ok;
  logic [DW-1:0]   full_byte;

  assign full_byte = {shreg, sda_s};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      ack        <= AK_NONE;
      bitcnt     <= '0;
      shreg      <= '0;
      ptr        <= '0;
      ptr_ok     <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_en_o    <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_det) begin
        phase      <= PH_ADDR;
        ack        <= AK_NONE;
        bitcnt     <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        phase      <= PH_IDLE;
        ack        <= AK_NONE;
        sda_pull_o <= 1'b0;
      end else if (ack == AK_WAIT && scl_fall) begin
        ack        <= AK_DRIVE;
        sda_pull_o <= 1'b1;
      end else if (ack == AK_DRIVE && scl_fall) begin
        ack        <= AK_NONE;
        sda_pull_o <= 1'b0;
      end else if (scl_rise && ack == AK_NONE && phase != PH_IDLE) begin
        shreg  <= full_byte[DW-2:0];
        bitcnt <= (bitcnt == LASTBIT) ? '0 : bitcnt + 1'b1;
        if (bitcnt == LASTBIT) begin
          case (phase)
            PH_ADDR: begin
              if (full_byte[DW-1:1] == {DEV_HI, strap_i} && !full_byte[0]) begin
                ack   <= AK_WAIT;
                phase <= PH_SUB;
              end else begin
                phase <= PH_IDLE;
              end
            end
            PH_SUB: begin
              ptr    <= full_byte[PW-1:0];
              ptr_ok <= (full_byte[DW-1:PW] == '0) && (full_byte[PW-1:0] <= LASTP);
              ack    <= AK_WAIT;
              phase  <= PH_DATA;
            end
            PH_DATA: begin
              ack <= AK_WAIT;
              if (ptr_ok) begin
                wr_en_o   <= 1'b1;
                wr_addr_o <= ptr;
                wr_data_o <= full_byte;
                ptr       <= (ptr == LASTP) ? '0 : ptr + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s); // R4
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull_o); // R1
  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |-> wr_addr_o <= LASTP); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o == LASTP) |-> ptr == '0); // R6
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_o && wr_addr_o != LASTP) |-> ptr == PW'(wr_addr_o + 1'b1)); // R6
endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank #(
  parameter int DW   = 8,
  parameter int PW   = 5,
  parameter int NREG = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [PW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [PW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam logic [PW-1:0] LASTP = PW'(NREG - 1);

  logic [DW-1:0] regs [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (wr_en_i && wr_addr_i == PW'(g)) regs[g] <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_addr_i <= LASTP) ? regs[rd_addr_i] : '0;

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i <= LASTP) |=> regs[$past(wr_addr_i)] == $past(wr_data_i)); // R5
endmodule

// File: rtl/i2cw_slave.sv
module i2cw_slave #(
  parameter int DW          = 8,
  parameter int PW          = 5,
  parameter int NREG        = 20,
  parameter int SYNC_STAGES = 2,
  parameter logic [DW-3:0] DEV_HI = 6'b001000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          strap_i,
  output logic          sda_pull_o,
  input  logic [PW-1:0] reg_sel_i,
  output logic [DW-1:0] reg_val_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic          wr_en;
  logic [PW-1:0] wr_addr;
  logic [DW-1:0] wr_data;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2cw_engine #(.DW(DW), .PW(PW), .NREG(NREG), .DEV_HI(DEV_HI)) u_engine (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .strap_i(strap_i),
    .sda_pull_o(sda_pull_o), .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  i2cw_regbank #(.DW(DW), .PW(PW), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(reg_sel_i), .rd_data_o(reg_val_o)
  );
endmodule

// File: tb/tb_i2cw_slave.sv
`timescale 1ns/1ps
module tb_i2cw_slave;
  localparam int HALF = 10;
  localparam int NREG = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
  logic [4:0] sel = '0;
  logic [7:0] val;
  logic pull, sda_bus;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] model [NREG];
  int mptr = 0;
  bit mok = 0;

  always #2.5 clk = ~clk;
  assign sda_bus = sda_m & ~pull;

  i2cw_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .sda_pull_o(pull), .reg_sel_i(sel), .reg_val_o(val)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(HALF);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b0; tick(HALF);
    scl_m = 1'b0; tick(HALF/2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(HALF/2);
    scl_m = 1'b1; tick(HALF);
    sda_m = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(HALF/2);
      scl_m = 1'b1; tick(HALF);
      scl_m = 1'b0; tick(HALF/2);
    end
    sda_m = 1'b1; tick(HALF/2);
    scl_m = 1'b1; tick(HALF/2);
    acked = !sda_bus;
    tick(HALF/2);
    scl_m = 1'b0; tick(HALF/2);
    if (acked) check("R4 ack released after ninth clock", pull, 0);
  endtask

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((seed * 37 + k * 11 + 5) & 8'hFF);
  endfunction

  // Full write: device byte, sub-address, n data bytes, STOP; model updated
  task automatic write_burst(input logic [7:0] sub, input int n, input int seed, input string req);
    bit a;
    bus_start();
    send_byte({6'b001000, strap, 1'b0}, a);
    check({req, " R2 address ack"}, a, 1);
    send_byte(sub, a);
    check({req, " R5 sub-address ack"}, a, 1);
    mptr = int'(sub[4:0]);
    mok  = (sub[7:5] == 3'b000) && (sub[4:0] <= 5'h13);
    for (int k = 0; k < n; k++) begin
      send_byte(pat(seed, k), a);
      check({req, " data ack"}, a, 1);
      if (mok) begin
        model[mptr] = pat(seed, k);
        mptr = (mptr == NREG - 1) ? 0 : mptr + 1;
      end
    end
    bus_stop();
  endtask

  task automatic check_regs(input string req);
    for (int i = 0; i < 32; i++) begin
      sel = 5'(i);
      tick(1);
      check(req, val, (i < NREG) ? model[i] : 0);
    end
  endtask

  initial begin
    bit a;
    for (int i = 0; i < NREG; i++) model[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // R9 reset state, R10 readout of unused selects
    check("R9 pull low after reset", pull, 0);
    check_regs("R9/R10 reset contents");

    // R5 fill every register in one burst
    write_burst(8'h00, NREG, 1, "R5 full burst");
    check_regs("R5 full burst readback");

    // R6 wrap past 13h
    write_burst(8'h12, 5, 2, "R6 wrap");
    check_regs("R6 wrap readback");

    // R6 sweep every start pointer with two bytes
    for (int s = 0; s < NREG; s++) write_burst(8'(s), 2, 10 + s, "R6 sweep");
    check_regs("R6 sweep readback");

    // R3 every non-matching address, then one more byte
    for (int ad = 0; ad < 128; ad++) begin
      if (ad == 8'h10) continue;
      bus_start();
      send_byte({7'(ad), 1'b0}, a);
      check("R3 mismatch nack", a, 0);
      send_byte(8'h00, a);
      check("R3 ignored byte nack", a, 0);
      bus_stop();
    end
    bus_start();
    send_byte({7'h10, 1'b1}, a);
    check("R3 read direction nack", a, 0);
    send_byte(8'h5A, a);
    check("R3 read direction ignored", a, 0);
    bus_stop();
    check_regs("R3 registers unchanged");

    // R2 strap selects lowest address bit
    strap = 1'b1;
    bus_start();
    send_byte({7'h10, 1'b0}, a);
    check("R2 strap=1 rejects 10h", a, 0);
    bus_stop();
    write_burst(8'h04, 3, 77, "R2 strap=1");
    check_regs("R2 strap=1 readback");

    // R7 invalid sub-addresses
    write_burst(8'h14, 3, 90, "R7 sub 14h");
    write_burst(8'h1F, 2, 91, "R7 sub 1Fh");
    write_burst(8'h23, 2, 92, "R7 upper bits");
    write_burst(8'hE0, 2, 93, "R7 upper bits");
    check_regs("R7 registers unchanged");

    // R8 repeated START after a data byte and after the address byte
    bus_start();
    send_byte({6'b001000, strap, 1'b0}, a);
    send_byte(8'h03, a);
    send_byte(8'hC3, a);
    model[3] = 8'hC3;
    bus_start();
    send_byte({6'b001000, strap, 1'b0}, a);
    check("R8 address after repeated START", a, 1);
    bus_start();
    send_byte({6'b001000, strap, 1'b0}, a);
    send_byte(8'h07, a);
    check("R8 sub after repeated START", a, 1);
    send_byte(8'h7E, a);
    model[7] = 8'h7E;
    bus_stop();
    check_regs("R8 readback");

    // R1 bytes after STOP without START are ignored
    scl_m = 1'b0; tick(HALF/2);
    send_byte({6'b001000, strap, 1'b0}, a);
    check("R1 no ack without START", a, 0);
    send_byte(8'h00, a);
    check("R1 no ack without START", a, 0);
    send_byte(8'hFF, a);
    check("R1 no ack without START", a, 0);
    scl_m = 1'b1; tick(HALF);
    check_regs("R1 registers unchanged");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule